// File: doc/BRIEF.md
# Manchester Word Encoder for a 1 Mb/s Avionics Serial Bus

This block turns one 16-bit parallel word from the processor side into a single serial word of 20 bit times on the bus. Each word starts with a synchronisation pattern three bit times long. The shape of that pattern depends on the word type, so a receiver can tell a command/status word from a data word. Sixteen data bits follow, most significant first, and then one odd-parity bit. The data and parity bits are Manchester coded. The result drives a pair of complementary rails for the line transceiver. The block also drives the transceiver's transmit-inhibit line, which is released only while a word is on the line.

The parallel side is a valid/ready stream of single words. The block takes a word in any cycle where `in_valid` and `in_ready` are both high. `in_ready` falls on the next cycle and stays low for the whole word, so the block applies back-pressure for one full word time. While `in_ready` is low, `in_valid` and the word inputs are ignored. The producer must hold its word until it is taken. The block never buffers a second word. After a word ends, `in_ready` rises in the following cycle, so consecutive words are separated by at least one idle clock.

Timing comes from the block clock, which is nominally 16 MHz. Each half bit lasts `HALF_TICKS` clocks (default 8), which gives the 1 Mb/s line rate. Message formatting, gaps between messages and bus arbitration belong to the logic around this block.

Top module: `mwe_word_encoder`

## Requirements
- R1: After reset, `tx_pos` and `tx_neg` are low, `tx_inhibit` is high and `in_ready` is high.
- R2: An accepted word occupies exactly 40 half-cells of `HALF_TICKS` clocks each (320 clocks by default), starting in the cycle after acceptance.
- R3: When `in_type` is 1 (command/status), the sync drives the line high for the first 3 half-cells and low for the next 3.
- R4: When `in_type` is 0 (data), the sync drives the line low for the first 3 half-cells and high for the next 3.
- R5: Data bits follow the sync, bit 15 first. A 1 is sent as a high half-cell then a low half-cell; a 0 is sent as low then high.
- R6: The last bit cell carries odd parity, so that the 16 data bits plus parity hold an odd number of ones. It is coded like a data bit.
- R7: While a word is sent, `tx_neg` is always the complement of `tx_pos` (the line level is `tx_pos`). When idle, both rails are low.
- R8: `tx_inhibit` is low exactly during the clocks of an accepted word and high at all other times.
- R9: `in_ready` is low for the whole word. Any `in_valid` pulse or input change during that time has no effect on the line.
- R10: `in_ready` rises in the cycle after the last half-cell ends. A word offered at that point begins after exactly one idle clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, nominally 16 MHz |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | A word is offered on `in_data`/`in_type` |
| in_ready | output | 1 | The block can take a word this cycle |
| in_data | input | DATA_W | Word to transmit |
| in_type | input | 1 | 1 selects command/status sync, 0 selects data sync |
| tx_pos | output | 1 | Positive transmit rail (line level) |
| tx_neg | output | 1 | Negative transmit rail |
| tx_inhibit | output | 1 | High blocks the transceiver's transmitter |

## Verification
A corrupted half-cell counter would show on the rails within one half-cell as an edge in the wrong place. It would also make the inhibit window longer or shorter than 320 clocks, which is visible when the word ends. A bad shift pattern or a bad parity calculation changes a rail level inside the word, at the exact clock where the wrong half-cell begins. A stuck activity flag shows at once: either inhibit stays low with no word accepted, or `in_ready` returns while the rails are still driving. The bench compares every transmitting clock against an independently built level stream, so any of these faults is reported in the cycle it first appears.

// File: rtl/mwe_pkg.sv
package mwe_pkg;
  // Half-cells used by the sync pattern (three bit times).
  localparam int unsigned SYNC_HALVES = 6;
  // Half-cells in one word for a given data width (data + parity coded).
  function automatic int unsigned word_halves(input int unsigned data_w);
    return SYNC_HALVES + 2 * (data_w + 1);
  endfunction
  typedef enum logic {
    WT_DATA = 1'b0,
    WT_CMD  = 1'b1
  } word_type_e;
endpackage

// File: rtl/mwe_halfcell_timer.sv
module mwe_halfcell_timer #(
  parameter int unsigned HALF_TICKS = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  input  logic run,
  output logic cell_end
);
  localparam int unsigned TW = (HALF_TICKS > 1) ? $clog2(HALF_TICKS) : 1;
  localparam logic [TW-1:0] LAST = TW'(HALF_TICKS - 1);

  logic [TW-1:0] tick_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tick_q <= '0;
    end else if (restart) begin
      tick_q <= '0;
    end else if (run) begin
      tick_q <= (tick_q == LAST) ? '0 : tick_q + 1'b1;
    end
  end

  assign cell_end = run && (tick_q == LAST);
endmodule

// File: rtl/mwe_pattern_gen.sv
module mwe_pattern_gen
  import mwe_pkg::*;
#(
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [DATA_W-1:0] in_data,
  input  word_type_e        in_type,
  input  logic              cell_end,
  output logic              active,
  output logic              level
);
  localparam int unsigned CELLS = word_halves(DATA_W);
  localparam int unsigned CW    = $clog2(CELLS);
  localparam logic [CW-1:0] LAST_IDX = CW'(CELLS - 1);

  logic [CELLS-1:0] fresh;
  logic [CELLS-1:0] pat_q;
  logic [CW-1:0]    left_q;
  logic             parity;
  logic             sync_first;

  assign parity     = ~^in_data;
  assign sync_first = (in_type == WT_CMD);

  // Sync: three half-cells at one level, three at the other.
  genvar s;
  generate
    for (s = 0; s < 3; s++) begin : g_sync
      assign fresh[CELLS-1-s] = sync_first;
      assign fresh[CELLS-4-s] = ~sync_first;
    end
  endgenerate

  // Data, most significant first, each bit as (bit, ~bit).
  genvar i;
  generate
    for (i = 0; i < DATA_W; i++) begin : g_bit
      localparam int unsigned HI = CELLS - 1 - SYNC_HALVES - 2 * i;
      assign fresh[HI]   = in_data[DATA_W-1-i];
      assign fresh[HI-1] = ~in_data[DATA_W-1-i];
    end
  endgenerate

  assign fresh[1] = parity;
  assign fresh[0] = ~parity;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active <= 1'b0;
      pat_q  <= '0;
      left_q <= '0;
    end else if (load) begin
      active <= 1'b1;
      pat_q  <= fresh;
      left_q <= LAST_IDX;
    end else if (cell_end) begin
      if (left_q == '0) begin
        active <= 1'b0;
      end else begin
        pat_q  <= pat_q << 1;
        left_q <= left_q - 1'b1;
      end
    end
  end

  assign level = pat_q[CELLS-1];
endmodule

// File: rtl/mwe_line_driver.sv
module mwe_line_driver (
  input  logic active,
  input  logic level,
  output logic tx_pos,
  output logic tx_neg,
  output logic tx_inhibit
);
  assign tx_pos     = active & level;
  assign tx_neg     = active & ~level;
  assign tx_inhibit = ~active;
endmodule

// File: rtl/mwe_word_encoder.sv
module mwe_word_encoder
  import mwe_pkg::*;
#(
  parameter int unsigned DATA_W     = 16,
  parameter int unsigned HALF_TICKS = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  input  logic              in_type,
  output logic              tx_pos,
  output logic              tx_neg,
  output logic              tx_inhibit
);
  logic active;
  logic level;
  logic cell_end;
  logic load;

  assign in_ready = ~active;
  assign load     = in_valid & ~active;

  mwe_halfcell_timer #(.HALF_TICKS(HALF_TICKS)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .restart  (load),
    .run      (active),
    .cell_end (cell_end)
  );

  mwe_pattern_gen #(.DATA_W(DATA_W)) u_pattern (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (load),
    .in_data  (in_data),
    .in_type  (word_type_e'(in_type)),
    .cell_end (cell_end),
    .active   (active),
    .level    (level)
  );

  mwe_line_driver u_line (
    .active     (active),
    .level      (level),
    .tx_pos     (tx_pos),
    .tx_neg     (tx_neg),
    .tx_inhibit (tx_inhibit)
  );
endmodule

// File: rtl/mwe_word_encoder_chk.sv
module mwe_word_encoder_chk
  import mwe_pkg::*;
#(
  parameter int unsigned DATA_W     = 16,
  parameter int unsigned HALF_TICKS = 8
) (
  input logic clk,
  input logic rst_n,
  input logic in_valid,
  input logic in_ready,
  input logic in_type,
  input logic tx_pos,
  input logic tx_neg,
  input logic tx_inhibit
);
  localparam int unsigned WORD_CLKS = word_halves(DATA_W) * HALF_TICKS;
  localparam int unsigned RW        = $clog2(WORD_CLKS + 2);

  logic [RW-1:0] run_q;

  always_ff @(posedge clk) begin
    if (!rst_n) run_q <= '0;
    else if (!tx_inhibit) run_q <= run_q + 1'b1;
    else run_q <= '0;
  end

  p_rails_compl_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_inhibit |-> (tx_pos != tx_neg));

  p_idle_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
    tx_inhibit |-> (!tx_pos && !tx_neg));

  p_start_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> (!tx_inhibit && !in_ready));

  p_sync_cmd_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && in_type) |=> tx_pos);

  p_sync_data_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && !in_type) |=> tx_neg);

  p_word_len_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_inhibit) |-> (run_q == RW'(WORD_CLKS)));

  p_no_overrun_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_inhibit |-> (run_q < RW'(WORD_CLKS)));
endmodule

bind mwe_word_encoder mwe_word_encoder_chk #(
  .DATA_W     (DATA_W),
  .HALF_TICKS (HALF_TICKS)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .in_valid   (in_valid),
  .in_ready   (in_ready),
  .in_type    (in_type),
  .tx_pos     (tx_pos),
  .tx_neg     (tx_neg),
  .tx_inhibit (tx_inhibit)
);

// File: tb/mwe_word_encoder_tb.sv
module mwe_word_encoder_tb;
  localparam int DATA_W     = 16;
  localparam int HALF_TICKS = 8;
  localparam int WORD_CLKS  = (6 + 2 * (DATA_W + 1)) * HALF_TICKS;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              in_valid = 1'b0;
  logic              in_ready;
  logic [DATA_W-1:0] in_data = '0;
  logic              in_type = 1'b0;
  logic              tx_pos, tx_neg, tx_inhibit;

  int errors = 0;
  int checks = 0;
  bit done = 0;
  int act_run = 0;
  int idle_run = 0;
  int last_gap = 0;
  bit    q_lvl[$];
  string q_tag[$];

  always #4 clk = ~clk;

  mwe_word_encoder #(.DATA_W(DATA_W), .HALF_TICKS(HALF_TICKS)) u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_type(in_type),
    .tx_pos(tx_pos), .tx_neg(tx_neg), .tx_inhibit(tx_inhibit)
  );

  task automatic check(bit ok, string tag, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic push_half(bit lvl, string tag);
    for (int k = 0; k < HALF_TICKS; k++) begin
      q_lvl.push_back(lvl);
      q_tag.push_back(tag);
    end
  endtask

  // Expected line levels built from the requirements.
  task automatic push_word(bit t, logic [DATA_W-1:0] d);
    int ones = 0;
    bit par;
    for (int h = 0; h < 3; h++) push_half(t, t ? "R3" : "R4");
    for (int h = 0; h < 3; h++) push_half(!t, t ? "R3" : "R4");
    for (int b = DATA_W - 1; b >= 0; b--) begin
      push_half(d[b], "R5");
      push_half(!d[b], "R5");
      if (d[b]) ones++;
    end
    par = (ones % 2 == 0);
    push_half(par, "R6");
    push_half(!par, "R6");
  endtask

  task automatic send(bit t, logic [DATA_W-1:0] d);
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    push_word(t, d);
    in_valid = 1'b1;
    in_type  = t;
    in_data  = d;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic wait_idle();
    @(negedge clk);
    while (!tx_inhibit) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  // Monitor: compare every clock against the scoreboard queue.
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (!tx_inhibit) begin
        if (idle_run != 0) begin
          last_gap = idle_run;
          idle_run = 0;
        end
        if (q_lvl.size() == 0) begin
          check(0, "R8", "inhibit released without a word", 0, 1);
        end else begin
          bit    lvl;
          string tg;
          lvl = q_lvl.pop_front();
          tg  = q_tag.pop_front();
          check(tx_pos == lvl && tx_neg == !lvl, tg, "rails",
                int'({tx_pos, tx_neg}), int'({lvl, !lvl}));
        end
        check(!in_ready, "R9", "ready during word", int'(in_ready), 0);
        act_run++;
      end else begin
        check(!tx_pos && !tx_neg, "R7", "idle rails", int'({tx_pos, tx_neg}), 0);
        check(in_ready, "R10", "ready when idle", int'(in_ready), 1);
        if (act_run != 0) begin
          check(act_run == WORD_CLKS, "R2", "word clocks", act_run, WORD_CLKS);
          act_run = 0;
        end
        idle_run++;
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    check(!tx_pos && !tx_neg, "R1", "rails in reset", int'({tx_pos, tx_neg}), 0);
    check(tx_inhibit, "R1", "inhibit in reset", int'(tx_inhibit), 1);
    rst_n = 1'b1;
    @(negedge clk);
    check(in_ready && tx_inhibit, "R1", "ready/inhibit after reset",
          int'({in_ready, tx_inhibit}), 3);

    // Distinct patterns, both word types.
    send(1'b1, 16'h0000);
    send(1'b0, 16'hFFFF);
    send(1'b1, 16'hA5C3);
    send(1'b0, 16'h8001);
    send(1'b0, 16'h0001);
    send(1'b1, 16'h7FFE);
    wait_idle();

    // R9: offers during a word are ignored.
    send(1'b0, 16'h3C3C);
    repeat (20) @(negedge clk);
    in_valid = 1'b1; in_type = 1'b1; in_data = 16'h1234;
    repeat (60) @(negedge clk);
    in_data = 16'hFFFF;
    repeat (60) @(negedge clk);
    in_valid = 1'b0;
    wait_idle();
    check(tx_inhibit, "R9", "no second word from ignored offer", int'(tx_inhibit), 1);
    check(q_lvl.size() == 0, "R9", "scoreboard drained", q_lvl.size(), 0);

    // R10: back-to-back words with a one-clock gap.
    send(1'b1, 16'h5555);
    send(1'b1, 16'hAAAA);
    @(negedge clk);
    check(last_gap == 1, "R10", "idle clocks between words", last_gap, 1);
    wait_idle();

    check(q_lvl.size() == 0, "R2", "all expected levels sent", q_lvl.size(), 0);
    check(tx_inhibit && in_ready, "R8", "idle at end",
          int'({tx_inhibit, in_ready}), 3);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule